// File: doc/BRIEF.md
# Parallel Flooding Min-Sum Accumulator Decoder

This block decodes the rate-1 accumulator code, where each coded bit is the running XOR of the data bits, in a fully parallel way. It is meant for the inner stage of a serially concatenated receiver. Each of the N positions has its own processing element that holds one forward message and one backward message. On every iteration clock all elements update together. Each update reads only the neighbour messages stored on the previous iteration, so the decoder works like a flooding LDPC decoder on a bidiagonal parity-check matrix. The check operation is the min-sum approximation.

A user presents N channel LLRs, N a-priori LLRs and an iteration count, then pulses `start`. The block clears its message storage and runs the programmed number of iterations. It then computes N extrinsic LLRs with the same combine rule as a serial forward/backward decoder and flags completion with a one-cycle `done`. When the count is at least N, the result matches the serial decoder exactly, because after N iterations the messages have had time to cross the whole chain.

Top module: `fdec_top`

## Requirements
- R1: After a synchronous active-low reset, `busy` and `done` are 0 and every `ext_llr` lane reads 0.
- R2: A `start` seen while idle is accepted at that clock edge (edge 0). With an iteration count K, `busy` is 1 after edges 0 through K. After edge K+1, `busy` is 0 and `done` is 1 for exactly one cycle.
- R3: A `start` seen while `busy` is 1 is ignored. The inputs are not captured again and the completion timing does not change.
- R4: On each iteration the forward message at position i becomes apr[i] ⊞ sat(ch[i-1] + fwd[i-1]), using previous-iteration values. Position 0 always takes apr[0].
- R5: On each iteration the backward message at position i becomes apr[i+1] ⊞ sat(ch[i+1] + bwd[i+1]), using previous-iteration values. The last position always holds 0.
- R6: At completion, extrinsic lane i equals sat(ch[i-1] + fwd[i-1]) ⊞ sat(bwd[i] + ch[i]). Lane 0 equals sat(bwd[0] + ch[0]).
- R7: The ⊞ operation returns the smaller magnitude of its two operands. The result is negative exactly when one operand is negative and the other is not, and a zero counts as non-negative.
- R8: Every LLR is two's complement W bits wide. Sums saturate symmetrically to ±(2^(W-1)-1). An input of -2^(W-1) is captured as -(2^(W-1)-1).
- R9: Message storage is cleared on each accepted start. With K = 0, lane i equals sat(ch[i-1]) ⊞ ch[i], and lane 0 equals ch[0].
- R10: When K ≥ N, the extrinsic lanes equal those of a serial min-sum forward/backward pass over the same inputs.
- R11: `ext_llr` holds its value until the next completion, whatever the data inputs do in between.
- R12: Lane i of every N·W-bit bus occupies bits [i·W +: W].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a decode when idle |
| iter_num | input | IW | Number of flooding iterations K |
| ch_llr | input | N·W | Channel LLRs of the coded bits |
| apr_llr | input | N·W | A-priori LLRs of the data bits |
| busy | output | 1 | Decode in progress |
| done | output | 1 | One-cycle completion pulse |
| ext_llr | output | N·W | Extrinsic LLRs of the data bits |

## Verification
The start edge is counted as edge 0. `busy` is due high after edges 0 to K, and `done` with fresh `ext_llr` is due after edge K+1. The bench samples at every falling edge between start and completion and compares `busy` and `done` against that count. It compares the lanes only in the cycle where `done` is due, and again several cycles later to check that they are held. The expected lanes come from a behavioural K-iteration flooding model and, for K ≥ N, from an independent serial pass.

// File: rtl/fdec_pkg.sv
// Shared types for the flooding accumulator decoder.
package fdec_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } fdec_state_t;
endpackage

// File: rtl/fdec_satadd.sv
// Signed adder that saturates symmetrically to +/-(2^(W-1)-1).
// Assumes two's complement operands of W bits. Also used with b_i = 0
// to clamp the most negative code.
module fdec_satadd #(
    parameter int W = 8
) (
    input  logic signed [W-1:0] a_i,
    input  logic signed [W-1:0] b_i,
    output logic signed [W-1:0] y_o
);
    localparam logic signed [W:0] HI = (W+1)'((2 ** (W-1)) - 1);
    localparam logic signed [W:0] LO = -HI;

    logic signed [W:0] sum;

    // widen, add, clamp
    always_comb begin
        sum = {a_i[W-1], a_i} + {b_i[W-1], b_i};
        if (sum > HI)      y_o = HI[W-1:0];
        else if (sum < LO) y_o = LO[W-1:0];
        else               y_o = sum[W-1:0];
    end
endmodule

// File: rtl/fdec_pe.sv
// One position of the flooding decoder. Holds the forward and backward
// messages of its coded bit. On step it updates both from the neighbour
// sums presented by the top, which are built from previous-iteration
// registers. Boundaries are injected by the top as fnb_i = +max (head)
// and apr_next_i = bnb_i = 0 (tail). Also forms the extrinsic combine.
module fdec_pe #(
    parameter int W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear_i,
    input  logic                step_i,
    input  logic signed [W-1:0] apr_self_i,
    input  logic signed [W-1:0] apr_next_i,
    input  logic signed [W-1:0] fnb_i,
    input  logic signed [W-1:0] bnb_i,
    input  logic signed [W-1:0] ch_self_i,
    output logic signed [W-1:0] fwd_o,
    output logic signed [W-1:0] bwd_o,
    output logic signed [W-1:0] ext_o
);
    logic signed [W-1:0] fwd_q, bwd_q, bsum;

    // min-sum check: sign product, smaller magnitude
    function automatic logic signed [W-1:0] chk_op(input logic signed [W-1:0] a,
                                                   input logic signed [W-1:0] b);
        logic signed [W-1:0] na, nb;
        logic [W-1:0] ma, mb, m;
        na = -a;
        nb = -b;
        ma = a[W-1] ? na : a;
        mb = b[W-1] ? nb : b;
        m  = (ma < mb) ? ma : mb;
        return (a[W-1] ^ b[W-1]) ? -$signed(m) : $signed(m);
    endfunction

    fdec_satadd #(.W(W)) u_bsum (.a_i(bwd_q), .b_i(ch_self_i), .y_o(bsum));

    // message registers: clear on start, flood update on step
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            fwd_q <= '0;
            bwd_q <= '0;
        end else if (step_i) begin
            fwd_q <= chk_op(apr_self_i, fnb_i);
            bwd_q <= chk_op(apr_next_i, bnb_i);
        end
    end

    // extrinsic combine of left and right evidence
    always_comb ext_o = chk_op(fnb_i, bsum);

    assign fwd_o = fwd_q;
    assign bwd_o = bwd_q;

    // R9
    msg_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (fwd_q == '0) && (bwd_q == '0));
endmodule

// File: rtl/fdec_ctrl.sv
// Iteration sequencer. Accepts start only when idle, issues K step
// pulses, then one finish pulse that loads the outputs. done follows
// finish by one register.
module fdec_ctrl #(
    parameter int IW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [IW-1:0] iter_i,
    output logic          clear_o,
    output logic          step_o,
    output logic          finish_o,
    output logic          busy_o,
    output logic          done_o
);
    import fdec_pkg::*;

    fdec_state_t   state_q;
    logic [IW-1:0] rem_q;

    assign clear_o  = start_i && (state_q == ST_IDLE);
    assign busy_o   = (state_q == ST_RUN);
    assign step_o   = busy_o && (rem_q != '0);
    assign finish_o = busy_o && (rem_q == '0);

    // state, remaining-iteration counter and done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rem_q   <= '0;
            done_o  <= 1'b0;
        end else begin
            done_o <= finish_o;
            if (clear_o) begin
                state_q <= ST_RUN;
                rem_q   <= iter_i;
            end else if (step_o) begin
                rem_q <= rem_q - 1'b1;
            end else if (finish_o) begin
                state_q <= ST_IDLE;
            end
        end
    end

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R2
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);
endmodule

// File: rtl/fdec_top.sv
// Parallel flooding min-sum decoder for the accumulator code. Captures
// clamped inputs on start, runs iter_num concurrent iterations across N
// processing elements, then registers the N extrinsic lanes. Lane i of
// each bus is bits [i*W +: W].
module fdec_top #(
    parameter int N  = 8,
    parameter int W  = 8,
    parameter int IW = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [IW-1:0]   iter_num,
    input  logic [N*W-1:0]  ch_llr,
    input  logic [N*W-1:0]  apr_llr,
    output logic            busy,
    output logic            done,
    output logic [N*W-1:0]  ext_llr
);
    localparam logic signed [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};

    logic clear, step, finish;
    logic signed [W-1:0] ch_cl [N];
    logic signed [W-1:0] ap_cl [N];
    logic signed [W-1:0] ch_q  [N];
    logic signed [W-1:0] apr_q [N];
    logic signed [W-1:0] fwd   [N];
    logic signed [W-1:0] bwd   [N];
    logic signed [W-1:0] fnb   [N];
    logic signed [W-1:0] bnb   [N];
    logic signed [W-1:0] aprn  [N];
    logic signed [W-1:0] ext_c [N];
    logic signed [W-1:0] ext_q [N];

    fdec_ctrl #(.IW(IW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start), .iter_i(iter_num),
        .clear_o(clear), .step_o(step), .finish_o(finish),
        .busy_o(busy), .done_o(done)
    );

    for (genvar i = 0; i < N; i++) begin : g_pos
        fdec_satadd #(.W(W)) u_chin (.a_i(ch_llr[i*W +: W]),  .b_i('0), .y_o(ch_cl[i]));
        fdec_satadd #(.W(W)) u_apin (.a_i(apr_llr[i*W +: W]), .b_i('0), .y_o(ap_cl[i]));

        if (i == 0) begin : g_head
            assign fnb[i] = MAXV;
        end else begin : g_fwd
            fdec_satadd #(.W(W)) u_f (.a_i(ch_q[i-1]), .b_i(fwd[i-1]), .y_o(fnb[i]));
        end

        if (i == N-1) begin : g_tail
            assign bnb[i]  = '0;
            assign aprn[i] = '0;
        end else begin : g_bwd
            fdec_satadd #(.W(W)) u_b (.a_i(ch_q[i+1]), .b_i(bwd[i+1]), .y_o(bnb[i]));
            assign aprn[i] = apr_q[i+1];
        end

        fdec_pe #(.W(W)) u_pe (
            .clk(clk), .rst_n(rst_n), .clear_i(clear), .step_i(step),
            .apr_self_i(apr_q[i]), .apr_next_i(aprn[i]),
            .fnb_i(fnb[i]), .bnb_i(bnb[i]), .ch_self_i(ch_q[i]),
            .fwd_o(fwd[i]), .bwd_o(bwd[i]), .ext_o(ext_c[i])
        );

        assign ext_llr[i*W +: W] = ext_q[i];
    end

    // input capture on accepted start, result capture on finish
    always_ff @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (!rst_n) begin
                ch_q[i]  <= '0;
                apr_q[i] <= '0;
                ext_q[i] <= '0;
            end else begin
                if (clear) begin
                    ch_q[i]  <= ch_cl[i];
                    apr_q[i] <= ap_cl[i];
                end
                if (finish) ext_q[i] <= ext_c[i];
            end
        end
    end

    // R4
    head_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> fwd[0] == apr_q[0]);
    // R5
    tail_bwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bwd[N-1] == '0);
    // R3
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(ch_q[0]) && $stable(apr_q[N-1])));
    // R11
    ext_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(ext_llr));
endmodule

// File: tb/test_fdec_top.sv
`timescale 1ns/1ps
module test_fdec_top;
    localparam int N = 8, W = 8, IW = 5;
    localparam int MX = (2 ** (W-1)) - 1;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [IW-1:0] iter_num = '0;
    logic [N*W-1:0] ch_llr = '0, apr_llr = '0;
    logic busy, done;
    logic [N*W-1:0] ext_llr;

    int n_chk = 0, n_fail = 0;
    int c[N], a[N], expx[N];

    fdec_top #(.N(N), .W(W), .IW(IW)) i_fdec_top (
        .clk(clk), .rst_n(rst_n), .start(start), .iter_num(iter_num),
        .ch_llr(ch_llr), .apr_llr(apr_llr),
        .busy(busy), .done(done), .ext_llr(ext_llr)
    );

    always #2.5 clk = ~clk;

    function automatic int sat(int v);
        return (v > MX) ? MX : ((v < -MX) ? -MX : v);
    endfunction

    // R7 reference: sign product, smaller magnitude, zero non-negative
    function automatic int ms(int x, int y);
        int ax = (x < 0) ? -x : x;
        int ay = (y < 0) ? -y : y;
        int m  = (ax < ay) ? ax : ay;
        return ((x < 0) != (y < 0)) ? -m : m;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // flooding model over K iterations (R4, R5, R6, R8, R9)
    task automatic flood_model(input int k);
        int f[N], b[N], nf[N], nb[N], cc[N], aa[N];
        for (int i = 0; i < N; i++) begin
            cc[i] = sat(c[i]); aa[i] = sat(a[i]); f[i] = 0; b[i] = 0;
        end
        for (int it = 0; it < k; it++) begin
            for (int i = 0; i < N; i++) begin
                nf[i] = (i == 0) ? aa[0] : ms(aa[i], sat(cc[i-1] + f[i-1]));
                nb[i] = (i == N-1) ? 0 : ms(aa[i+1], sat(cc[i+1] + b[i+1]));
            end
            f = nf; b = nb;
        end
        for (int i = 0; i < N; i++)
            expx[i] = (i == 0) ? sat(b[0] + cc[0])
                               : ms(sat(cc[i-1] + f[i-1]), sat(b[i] + cc[i]));
    endtask

    // serial forward then backward pass (R10)
    task automatic serial_model();
        int f[N], b[N], cc[N], aa[N];
        for (int i = 0; i < N; i++) begin cc[i] = sat(c[i]); aa[i] = sat(a[i]); end
        f[0] = aa[0];
        for (int i = 1; i < N; i++) f[i] = ms(aa[i], sat(cc[i-1] + f[i-1]));
        b[N-1] = 0;
        for (int i = N-2; i >= 0; i--) b[i] = ms(aa[i+1], sat(cc[i+1] + b[i+1]));
        for (int i = 0; i < N; i++)
            expx[i] = (i == 0) ? sat(b[0] + cc[0])
                               : ms(sat(cc[i-1] + f[i-1]), sat(b[i] + cc[i]));
    endtask

    task automatic drive_bus();
        for (int i = 0; i < N; i++) begin
            ch_llr[i*W +: W]  = W'(c[i]);
            apr_llr[i*W +: W] = W'(a[i]);
        end
    endtask

    task automatic cmp_ext(input string req);
        for (int i = 0; i < N; i++) begin
            int act = $signed(ext_llr[i*W +: W]);
            chk(act == expx[i], req, act, expx[i]);
        end
    endtask

    // one decode: per-cycle busy/done check against R2, optional ignored start (R3)
    task automatic run(input int k, input bit poke, input string req);
        drive_bus();
        iter_num = IW'(k);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int j = 0; j <= k + 1; j++) begin
            chk(busy == (j <= k), "R2 busy", busy, (j <= k));
            chk(done == (j == k + 1), "R2 done", done, (j == k + 1));
            if (j == k + 1) cmp_ext(req);
            else begin
                if (poke && j == 0) begin
                    start = 1'b1;
                    ch_llr = ~ch_llr;
                    apr_llr = {N{8'sd5}};
                end
                @(negedge clk);
                start = 1'b0;
            end
        end
        @(negedge clk);
        chk(done == 1'b0, "R2 pulse", done, 0);
    endtask

    task automatic rand_in(input int lo, input int hi);
        for (int i = 0; i < N; i++) begin
            c[i] = $urandom_range(hi - lo) + lo;
            a[i] = $urandom_range(hi - lo) + lo;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(busy == 1'b0, "R1 busy", busy, 0);
        chk(done == 1'b0, "R1 done", done, 0);
        chk(ext_llr == '0, "R1 ext", int'(ext_llr[31:0]), 0);

        // R9: zero iterations uses cleared messages only
        rand_in(-40, 40);
        flood_model(0);
        run(0, 1'b0, "R9 K=0");

        // R4 R5 R6: partial flooding, mixed signs, lane layout R12
        rand_in(-60, 60);
        flood_model(1);
        run(1, 1'b0, "R4 K=1");
        flood_model(3);
        run(3, 1'b0, "R5 K=3");

        // R10: K = N equals serial pass
        rand_in(-100, 100);
        serial_model();
        run(N, 1'b0, "R10 K=N");

        // R10 with K > N and all-positive inputs, R7 zeros included
        rand_in(0, 30);
        c[2] = 0; a[5] = 0;
        serial_model();
        run(N + 4, 1'b0, "R10 K>N");

        // R8: extremes including the most negative code
        for (int i = 0; i < N; i++) begin
            c[i] = (i % 2) ? 127 : -128;
            a[i] = (i % 3 == 0) ? -128 : 120;
        end
        serial_model();
        run(N, 1'b0, "R8 sat");

        // R3: start during busy with other inputs is ignored
        rand_in(-70, 70);
        flood_model(4);
        run(4, 1'b1, "R3 ignore");

        // R11: outputs held while inputs change without start
        ch_llr = ~ch_llr;
        apr_llr = ~apr_llr;
        repeat (5) @(negedge clk);
        cmp_ext("R11 hold");
        chk(busy == 1'b0, "R11 idle", busy, 0);

        // R6 lane 0 and R7 sign with K=2 on negative-only inputs
        rand_in(-90, -1);
        flood_model(2);
        run(2, 1'b0, "R6 K=2");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule